// File: doc/BRIEF.md
# Dual-Port Stream Priority Arbiter

This block chooses which of eight transfer streams may run next, separately for two bus master ports: one that faces memory and one that faces peripherals. Each port has its own request vector, its own table of two-bit priority levels, a done pulse and a one-hot grant with a valid flag. When a port is free, it first looks at the requesting streams with the highest programmed level. Among those it takes the one with the smallest stream index. The grant it issues starts that stream's access sequence on the port.

A grant stays in place until the port pulses done. Requests that arrive or change in the meantime, including higher-priority ones, cannot preempt it. The grant/done pair acts as a valid/ready handshake with no back-pressure beyond that: grant_valid stays high and the grant holds steady until the owner raises done for one cycle. In that cycle the port re-arbitrates among the requests present, and the new grant shows on the next cycle. If nothing can be granted, grant_valid drops and the grant reads zero.

A stream may run on only one port at a time. Each port skips any stream that the other port holds. When both ports arbitrate in the same cycle, the memory port chooses first and the peripheral port skips the memory port's new choice. The peripheral port also keeps skipping a stream that the memory port is releasing in that same cycle.

Top module: `dual_port_stream_arb`

## Requirements
- R1: A synchronous active-high reset clears both grants to zero and drives both grant_valid outputs low on the next clock edge, whatever the requests are.
- R2: Stream s takes its level from bits [2s+1:2s] of its port's priority input, with 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. A requesting stream at a higher level always beats one at a lower level, regardless of index.
- R3: Among eligible requesting streams that share the highest level present, the one with the lowest index wins (stream 2 beats stream 4).
- R4: While grant_valid is high and done is low, the grant and grant_valid hold unchanged on the next cycle. Requests and priorities have no effect on them during that time.
- R5: A port that is idle, or that sees done, loads the winner of that cycle's requests at the clock edge. If there is no eligible request, grant_valid goes low and the grant is all zeros.
- R6: A stream granted on one port is never granted on the other port in the same cycle. When both ports arbitrate together, the memory port picks first and the peripheral port excludes that pick.
- R7: When grant_valid is high, the grant has exactly one bit set, and that stream was requesting in the cycle the grant was taken. When grant_valid is low, the grant is zero.
- R8: A done pulse on an idle port has no effect beyond normal arbitration of the requests present.
- R9: Each port arbitrates only with its own request and priority inputs, so the two ports may rank the same streams differently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 8 | Memory-port request, one bit per stream |
| mem_prio | input | 16 | Memory-port priority levels, two bits per stream |
| mem_done | input | 1 | Memory-port access-complete pulse |
| mem_grant | output | 8 | Memory-port one-hot grant |
| mem_grant_valid | output | 1 | Memory-port grant is active |
| per_req | input | 8 | Peripheral-port request, one bit per stream |
| per_prio | input | 16 | Peripheral-port priority levels, two bits per stream |
| per_done | input | 1 | Peripheral-port access-complete pulse |
| per_grant | output | 8 | Peripheral-port one-hot grant |
| per_grant_valid | output | 1 | Peripheral-port grant is active |

## Verification
The bench checks preemption by raising a very-high request while a low-level grant is held; a design that got this wrong would switch streams before done. It puts the lowest index at a lower level than a higher index, and also at the same level, so that a design that swapped the two stages would pick the wrong stream. It asks both ports for the same stream in the same cycle, and also while one port holds that stream, where a weak mask would produce a duplicate grant. It also releases a port with no requests left and pulses done on an idle port, where a design might keep a stale grant or drop a real one.

// File: rtl/dpsa_pkg.sv
package dpsa_pkg;
  localparam int unsigned NUM_STREAMS = 8;
  localparam int unsigned PRIO_W      = 2;

  typedef enum logic [PRIO_W-1:0] {
    LVL_LOW   = 2'b00,
    LVL_MED   = 2'b01,
    LVL_HIGH  = 2'b10,
    LVL_VHIGH = 2'b11
  } lvl_e;
endpackage

// File: rtl/dpsa_pick.sv
// Combinational two-stage winner selection: highest level first, then
// the lowest index among the streams at that level.
module dpsa_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    mask,
  input  logic [N*PW-1:0] prio,
  output logic [N-1:0]    pick,
  output logic            found
);
  localparam int unsigned NLVL = 1 << PW;

  logic [N-1:0] elig;
  logic [N-1:0] at_lvl [NLVL];
  logic [N-1:0] cand;

  assign elig = req & ~mask;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar s = 0; s < N; s++) begin : g_str
      assign at_lvl[l][s] = elig[s] && (prio[s*PW +: PW] == PW'(l));
    end
  end

  // Scan upward so the highest populated level is the one left in cand.
  always_comb begin
    cand = '0;
    for (int k = 0; k < NLVL; k++) begin
      if (|at_lvl[k]) cand = at_lvl[k];
    end
  end

  // Isolate the lowest set bit: the smallest stream index wins a tie.
  assign pick  = cand & (~cand + N'(1));
  assign found = |cand;
endmodule

// File: rtl/dpsa_slot.sv
// Per-port grant holder: locks the grant until done, then reloads.
module dpsa_slot #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done,
  input  logic [N-1:0] pick,
  input  logic         found,
  output logic         arbitrate,
  output logic [N-1:0] grant,
  output logic         valid
);
  logic [N-1:0] grant_q;
  logic         valid_q;

  assign arbitrate = !valid_q || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      valid_q <= 1'b0;
    end else if (arbitrate) begin
      grant_q <= found ? pick : '0;
      valid_q <= found;
    end
  end

  assign grant = grant_q;
  assign valid = valid_q;
endmodule

// File: rtl/dual_port_stream_arb.sv
module dual_port_stream_arb
  import dpsa_pkg::*;
#(
  parameter int unsigned N  = NUM_STREAMS,
  parameter int unsigned PW = PRIO_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    mem_req,
  input  logic [N*PW-1:0] mem_prio,
  input  logic            mem_done,
  output logic [N-1:0]    mem_grant,
  output logic            mem_grant_valid,
  input  logic [N-1:0]    per_req,
  input  logic [N*PW-1:0] per_prio,
  input  logic            per_done,
  output logic [N-1:0]    per_grant,
  output logic            per_grant_valid
);
  logic [N-1:0] mem_mask, per_mask;
  logic [N-1:0] mem_pick, per_pick;
  logic         mem_found, per_found;
  logic         mem_arb, per_arb;
  logic [N-1:0] mem_take;

  // Memory port chooses first; it only avoids what the peripheral holds.
  assign mem_mask = per_grant;
  // Peripheral avoids what memory holds or is taking this cycle.
  assign mem_take = mem_arb ? mem_pick : '0;
  assign per_mask = mem_grant | mem_take;

  dpsa_pick #(.N(N), .PW(PW)) u_mem_pick (
    .req(mem_req), .mask(mem_mask), .prio(mem_prio),
    .pick(mem_pick), .found(mem_found)
  );

  dpsa_pick #(.N(N), .PW(PW)) u_per_pick (
    .req(per_req), .mask(per_mask), .prio(per_prio),
    .pick(per_pick), .found(per_found)
  );

  dpsa_slot #(.N(N)) u_mem_slot (
    .clk(clk), .rst(rst), .done(mem_done),
    .pick(mem_pick), .found(mem_found), .arbitrate(mem_arb),
    .grant(mem_grant), .valid(mem_grant_valid)
  );

  dpsa_slot #(.N(N)) u_per_slot (
    .clk(clk), .rst(rst), .done(per_done),
    .pick(per_pick), .found(per_found), .arbitrate(per_arb),
    .grant(per_grant), .valid(per_grant_valid)
  );
endmodule

// File: rtl/dpsa_chk.sv
module dpsa_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] mem_req,
  input logic         mem_done,
  input logic [N-1:0] mem_grant,
  input logic         mem_grant_valid,
  input logic [N-1:0] per_req,
  input logic         per_done,
  input logic [N-1:0] per_grant,
  input logic         per_grant_valid
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_grant_valid && !per_grant_valid &&
                    mem_grant == '0 && per_grant == '0));

  p_mem_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_grant_valid && !mem_done) |=> (mem_grant_valid && $stable(mem_grant)));

  p_per_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (per_grant_valid && !per_done) |=> (per_grant_valid && $stable(per_grant)));

  p_mem_empty_r5: assert property (@(posedge clk) disable iff (rst)
    ((!mem_grant_valid || mem_done) && mem_req == '0) |=> !mem_grant_valid);

  p_per_empty_r5: assert property (@(posedge clk) disable iff (rst)
    ((!per_grant_valid || per_done) && per_req == '0) |=> !per_grant_valid);

  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_grant & per_grant) == '0);

  p_mem_shape_r7: assert property (@(posedge clk) disable iff (rst)
    mem_grant_valid ? ($countones(mem_grant) == 1) : (mem_grant == '0));

  p_per_shape_r7: assert property (@(posedge clk) disable iff (rst)
    per_grant_valid ? ($countones(per_grant) == 1) : (per_grant == '0));

  p_mem_requested_r7: assert property (@(posedge clk) disable iff (rst)
    (!mem_grant_valid || mem_done) |=>
      (!mem_grant_valid || (mem_grant & $past(mem_req)) != '0));

  p_per_requested_r7: assert property (@(posedge clk) disable iff (rst)
    (!per_grant_valid || per_done) |=>
      (!per_grant_valid || (per_grant & $past(per_req)) != '0));
endmodule

bind dual_port_stream_arb dpsa_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst),
  .mem_req(mem_req), .mem_done(mem_done),
  .mem_grant(mem_grant), .mem_grant_valid(mem_grant_valid),
  .per_req(per_req), .per_done(per_done),
  .per_grant(per_grant), .per_grant_valid(per_grant_valid)
);

// File: tb/dual_port_stream_arb_bench.sv
module dual_port_stream_arb_bench;
  typedef struct packed {
    logic [3:0]  rq;     // requirement number for messages
    logic [7:0]  mreq;
    logic [15:0] mprio;
    logic        mdone;
    logic [7:0]  preq;
    logic [15:0] pprio;
    logic        pdone;
    logic [7:0]  emg;
    logic        emv;
    logic [7:0]  epg;
    logic        epv;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd5, 8'h00, 16'h0000, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R5 idle
    '{4'd3, 8'h14, 16'h0000, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h04, 1'b1, 8'h00, 1'b0}, // R3 2 beats 4
    '{4'd4, 8'hFF, 16'hFFFF, 1'b0, 8'h04, 16'h0000, 1'b0, 8'h04, 1'b1, 8'h00, 1'b0}, // R4 hold, R6 skip
    '{4'd2, 8'h90, 16'hC200, 1'b1, 8'h04, 16'h0000, 1'b0, 8'h80, 1'b1, 8'h00, 1'b0}, // R2 7 over 4
    '{4'd6, 8'h90, 16'hC200, 1'b0, 8'h04, 16'h0000, 1'b0, 8'h80, 1'b1, 8'h04, 1'b1}, // R6 released
    '{4'd2, 8'h90, 16'hC200, 1'b0, 8'hFF, 16'h3C00, 1'b1, 8'h80, 1'b1, 8'h20, 1'b1}, // R2/R3 5 of 5,6
    '{4'd6, 8'h90, 16'hC200, 1'b0, 8'h82, 16'hC004, 1'b1, 8'h80, 1'b1, 8'h02, 1'b1}, // R6 7 held
    '{4'd5, 8'h00, 16'h0000, 1'b1, 8'h82, 16'hC004, 1'b0, 8'h00, 1'b0, 8'h02, 1'b1}, // R5 empty
    '{4'd8, 8'h00, 16'h0000, 1'b1, 8'h82, 16'hC004, 1'b0, 8'h00, 1'b0, 8'h02, 1'b1}, // R8 idle done
    '{4'd6, 8'h02, 16'h0000, 1'b0, 8'h82, 16'hC004, 1'b0, 8'h00, 1'b0, 8'h02, 1'b1}, // R6 1 held
    '{4'd9, 8'h06, 16'h0030, 1'b0, 8'h06, 16'h0000, 1'b1, 8'h04, 1'b1, 8'h02, 1'b1}, // R9 rankings
    '{4'd6, 8'h09, 16'h0040, 1'b1, 8'h08, 16'h0000, 1'b1, 8'h08, 1'b1, 8'h00, 1'b0}, // R6 mem first
    '{4'd2, 8'h41, 16'h3002, 1'b1, 8'h00, 16'h0000, 1'b0, 8'h40, 1'b1, 8'h00, 1'b0}, // R2 level over index
    '{4'd3, 8'h41, 16'h3003, 1'b1, 8'h00, 16'h0000, 1'b0, 8'h01, 1'b1, 8'h00, 1'b0}, // R3 tie at top
    '{4'd6, 8'h41, 16'h3003, 1'b0, 8'h01, 16'h0000, 1'b0, 8'h01, 1'b1, 8'h00, 1'b0}  // R6 0 held
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  mem_req, per_req, mem_grant, per_grant;
  logic [15:0] mem_prio, per_prio;
  logic        mem_done, per_done, mem_grant_valid, per_grant_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_port_stream_arb u_dual_port_stream_arb (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_prio(mem_prio), .mem_done(mem_done),
    .mem_grant(mem_grant), .mem_grant_valid(mem_grant_valid),
    .per_req(per_req), .per_prio(per_prio), .per_done(per_done),
    .per_grant(per_grant), .per_grant_valid(per_grant_valid)
  );

  task automatic check(input int rq, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mem_req = v.mreq; mem_prio = v.mprio; mem_done = v.mdone;
    per_req = v.preq; per_prio = v.pprio; per_done = v.pdone;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive('0);
    repeat (3) @(posedge clk);
    #1;
    // R1: state after reset
    check(1, "mem grant after reset", mem_grant, 8'h00);
    check(1, "mem valid after reset", {7'd0, mem_grant_valid}, 8'h00);
    check(1, "per grant after reset", per_grant, 8'h00);
    check(1, "per valid after reset", {7'd0, per_grant_valid}, 8'h00);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(TBL[i]);
      @(posedge clk);
      #1;
      check(TBL[i].rq, $sformatf("v%0d mem grant", i), mem_grant, TBL[i].emg);
      check(TBL[i].rq, $sformatf("v%0d mem valid", i), {7'd0, mem_grant_valid}, {7'd0, TBL[i].emv});
      check(TBL[i].rq, $sformatf("v%0d per grant", i), per_grant, TBL[i].epg);
      check(TBL[i].rq, $sformatf("v%0d per valid", i), {7'd0, per_grant_valid}, {7'd0, TBL[i].epv});
    end

    // R1: reset while both ports hold grants and requests stay up
    @(negedge clk);
    mem_req = 8'h41; mem_prio = 16'h3003; mem_done = 1'b0;
    per_req = 8'h02; per_prio = 16'h0000; per_done = 1'b0;
    @(posedge clk); #1;
    check(6, "per takes 1 beside mem 0", per_grant, 8'h02);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check(1, "mem grant in-flight reset", mem_grant, 8'h00);
    check(1, "per valid in-flight reset", {7'd0, per_grant_valid}, 8'h00);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check(5, "mem regrant after reset", mem_grant, 8'h01);
    check(5, "per regrant after reset", per_grant, 8'h02);

    // R4: very-high newcomer cannot preempt a low grant on the peripheral port
    @(negedge clk) per_req = 8'h82; per_prio = 16'hC000;
    @(posedge clk); #1;
    check(4, "per no preempt", per_grant, 8'h02);
    // R2: after done, the very-high stream 7 wins
    @(negedge clk) per_done = 1'b1;
    @(posedge clk); #1;
    check(2, "per very high after done", per_grant, 8'h80);
    @(negedge clk) per_done = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule